// File: doc/BRIEF.md
# Dual-Adder Interlocked Issue Pipeline

This block is a four-stage integer pipeline that runs a stream of register-to-register additions. Each word enters a fetch register, moves to a decode register, and decode sends it to one of two adders. Each adder is not pipelined and is busy for two cycles. A result then spends one cycle in a write-back register of its own. Each adder therefore has a private write port into the register file.

Decode holds an instruction for two reasons. It waits while any of its source registers is still the destination of an addition in an adder. It also waits while both adders are busy. During such a hold, fetch and decode are frozen. The only bypass is through the register file: a value written in a cycle can be read by decode in that same cycle. A free-running cycle counter and a retire counter are provided so that a schedule worked out by hand can be checked against the hardware.

Top module: `dual_adder_pipe`

## Requirements
- R1: After reset, register i holds the value i, both write ports are idle, `fetch_ready` is high, and both counters read zero. An instruction word is {rd, rs1, rs2}, each field AW bits wide, with rd in the most significant field and rs2 in the least significant field.
- R2: Each instruction writes rs1 + rs2 into rd, using the source values current when it leaves decode.
- R3: An instruction that leaves decode at the end of cycle t is written back on its adder's port during cycle t+3. The adder accepts no other instruction during cycles t+1 and t+2.
- R4: An instruction leaving decode goes to the lowest-numbered idle adder. An adder in its write-back cycle counts as idle. An adder in its last execute cycle does not. With no idle adder, decode holds the instruction.
- R5: While decode holds an instruction, the word in fetch does not move, and `fetch_ready` stays low once fetch is occupied. A new word is accepted in any cycle where `in_valid` and `fetch_ready` are both high.
- R6: A source register that is being written back in a cycle counts as ready for decode in that same cycle, and decode reads the value being written.
- R7: `cycle_count` rises by one every cycle after reset. `retire_count` rises by the number of write ports active in the previous cycle.
- R8: Sums wrap modulo 2^DW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction word is offered |
| in_word | input | 3*AW | Instruction {rd, rs1, rs2} |
| fetch_ready | output | 1 | Fetch takes the offered word at this edge |
| wr_en | output | NUM_ADDERS | Write strobe, one per adder port |
| wr_addr | output | NUM_ADDERS*AW | Destination register per port, port 0 in the low bits |
| wr_data | output | NUM_ADDERS*DW | Written value per port, port 0 in the low bits |
| cycle_count | output | CW | Cycles since reset |
| retire_count | output | CW | Results written since reset |

## Verification
Two things can happen in one cycle. An adder writes back a register, and in that same cycle decode reads the register and may send a new instruction to the adder that is writing back. A dependent chain provokes the first case: each link has to leave decode exactly in its producer's write-back cycle. A run of four independent additions provokes the second: the third addition has to wait for adder 0 to reach write-back, and it then reuses that adder. The bench builds each instruction's write cycle, port and value from scheduling rules stated in the requirements. It compares every port and counter against that schedule on every clock.

// File: rtl/dap_pkg.sv
package dap_pkg;
    localparam int DEF_NREG = 16;
    localparam int DEF_DW   = 16;
    localparam int DEF_LAT  = 2;

    typedef enum logic [1:0] {
        SRC_OK      = 2'd0,
        SRC_HAZARD  = 2'd1,
        UNIT_FULL   = 2'd2
    } hold_cause_e;
endpackage

// File: rtl/dap_regfile.sv
module dap_regfile #(
    parameter int NREG   = 16,
    parameter int DW     = 16,
    parameter int NPORTS = 2,
    localparam int AW    = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NPORTS-1:0]    we,
    input  logic [NPORTS*AW-1:0] waddr,
    input  logic [NPORTS*DW-1:0] wdata,
    input  logic [AW-1:0]        raddr_a,
    input  logic [AW-1:0]        raddr_b,
    output logic [DW-1:0]        rdata_a,
    output logic [DW-1:0]        rdata_b
);
    typedef struct packed {
        logic [NREG-1:0][DW-1:0] regs;
    } rf_t;

    rf_t rf_d, rf_q;

    // Writes land first; reads see the updated array (same-cycle bypass).
    always_comb begin
        rf_d = rf_q;
        for (int p = 0; p < NPORTS; p++) begin
            if (we[p]) rf_d.regs[waddr[p*AW +: AW]] = wdata[p*DW +: DW];
        end
        rdata_a = rf_d.regs[raddr_a];
        rdata_b = rf_d.regs[raddr_b];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) rf_q.regs[i] <= DW'(i);
        end else begin
            rf_q <= rf_d;
        end
    end

    // R6: a port-0 write is visible afterwards unless port 1 overwrote it.
    assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (we[0] && !(NPORTS > 1 && we[NPORTS-1] && waddr[(NPORTS-1)*AW +: AW] == waddr[0 +: AW]))
        |=> rf_q.regs[$past(waddr[0 +: AW])] == $past(wdata[0 +: DW]));
endmodule

// File: rtl/dap_adder_unit.sv
module dap_adder_unit #(
    parameter int AW  = 4,
    parameter int DW  = 16,
    parameter int LAT = 2,
    localparam int CNTW = $clog2(LAT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic [AW-1:0] issue_rd,
    input  logic [DW-1:0] issue_a,
    input  logic [DW-1:0] issue_b,
    output logic          busy,
    output logic [AW-1:0] busy_rd,
    output logic          wb_en,
    output logic [AW-1:0] wb_rd,
    output logic [DW-1:0] wb_data
);
    typedef struct packed {
        logic            busy;
        logic [CNTW-1:0] cnt;
        logic [AW-1:0]   rd;
        logic [DW-1:0]   sum;
        logic            wb_valid;
        logic [AW-1:0]   wb_rd;
        logic [DW-1:0]   wb_data;
    } unit_t;

    unit_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.wb_valid = 1'b0;
        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy     = 1'b0;
                st_d.wb_valid = 1'b1;
                st_d.wb_rd    = st_q.rd;
                st_d.wb_data  = st_q.sum;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
        if (issue) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CNTW'(LAT - 1);
            st_d.rd   = issue_rd;
            st_d.sum  = issue_a + issue_b;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = st_q.busy;
    assign busy_rd = st_q.rd;
    assign wb_en   = st_q.wb_valid;
    assign wb_rd   = st_q.wb_rd;
    assign wb_data = st_q.wb_data;

    // R4: the issue logic must never target a busy adder.
    assert_issue_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> !busy);

    // R3: the last execute cycle is followed by write-back of the same destination.
    assert_wb_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st_q.cnt == '0 && !issue) |=> (wb_en && wb_rd == $past(busy_rd)));

    generate
        if (LAT >= 2) begin : g_span
            // R3: an adder stays occupied beyond its first execute cycle.
            assert_busy_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(busy) |=> busy);
        end
    endgenerate
endmodule

// File: rtl/dap_frontend.sv
module dap_frontend #(
    parameter int IW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [IW-1:0] in_word,
    input  logic          id_take,
    output logic          fetch_ready,
    output logic          id_valid,
    output logic [IW-1:0] id_word
);
    typedef struct packed {
        logic          if_valid;
        logic [IW-1:0] if_word;
        logic          id_valid;
        logic [IW-1:0] id_word;
    } fe_t;

    fe_t fe_d, fe_q;
    logic id_adv, if_adv;

    always_comb begin
        id_adv = !fe_q.id_valid || id_take;
        if_adv = !fe_q.if_valid || id_adv;
        fe_d   = fe_q;
        if (id_adv) begin
            fe_d.id_valid = fe_q.if_valid;
            fe_d.id_word  = fe_q.if_word;
        end
        if (if_adv) begin
            fe_d.if_valid = in_valid;
            fe_d.if_word  = in_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fe_q <= '0;
        end else begin
            fe_q <= fe_d;
        end
    end

    assign fetch_ready = if_adv;
    assign id_valid    = fe_q.id_valid;
    assign id_word     = fe_q.id_word;

    // R5: a held decode slot freezes the fetched word behind it.
    assert_fetch_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_q.if_valid && fe_q.id_valid && !id_take) |=> ($stable(fe_q.if_word) && fe_q.if_valid));
endmodule

// File: rtl/dual_adder_pipe.sv
module dual_adder_pipe #(
    parameter int NREG       = dap_pkg::DEF_NREG,
    parameter int DW         = dap_pkg::DEF_DW,
    parameter int NUM_ADDERS = 2,
    parameter int EXEC_LAT   = dap_pkg::DEF_LAT,
    parameter int CW         = 32,
    localparam int AW        = $clog2(NREG),
    localparam int IW        = 3 * AW
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [IW-1:0]            in_word,
    output logic                     fetch_ready,
    output logic [NUM_ADDERS-1:0]    wr_en,
    output logic [NUM_ADDERS*AW-1:0] wr_addr,
    output logic [NUM_ADDERS*DW-1:0] wr_data,
    output logic [CW-1:0]            cycle_count,
    output logic [CW-1:0]            retire_count
);
    import dap_pkg::*;

    typedef struct packed {
        logic [CW-1:0] cycles;
        logic [CW-1:0] retired;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    logic                  id_valid;
    logic [IW-1:0]         id_word;
    logic [AW-1:0]         dec_rd, dec_rs1, dec_rs2;
    logic [DW-1:0]         src_a, src_b;
    logic [NUM_ADDERS-1:0] unit_busy;
    logic [NUM_ADDERS*AW-1:0] unit_rd;
    logic [NUM_ADDERS-1:0] issue_sel;
    logic                  dispatch;
    hold_cause_e           hold_cause;

    dap_frontend #(.IW(IW)) u_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_word    (in_word),
        .id_take    (dispatch),
        .fetch_ready(fetch_ready),
        .id_valid   (id_valid),
        .id_word    (id_word)
    );

    assign dec_rd  = id_word[2*AW +: AW];
    assign dec_rs1 = id_word[AW +: AW];
    assign dec_rs2 = id_word[0 +: AW];

    dap_regfile #(.NREG(NREG), .DW(DW), .NPORTS(NUM_ADDERS)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (wr_en),
        .waddr  (wr_addr),
        .wdata  (wr_data),
        .raddr_a(dec_rs1),
        .raddr_b(dec_rs2),
        .rdata_a(src_a),
        .rdata_b(src_b)
    );

    generate
        for (genvar u = 0; u < NUM_ADDERS; u++) begin : g_unit
            dap_adder_unit #(.AW(AW), .DW(DW), .LAT(EXEC_LAT)) u_add (
                .clk     (clk),
                .rst_n   (rst_n),
                .issue   (issue_sel[u]),
                .issue_rd(dec_rd),
                .issue_a (src_a),
                .issue_b (src_b),
                .busy    (unit_busy[u]),
                .busy_rd (unit_rd[u*AW +: AW]),
                .wb_en   (wr_en[u]),
                .wb_rd   (wr_addr[u*AW +: AW]),
                .wb_data (wr_data[u*DW +: DW])
            );
        end
    endgenerate

    // Scoreboard: a register is pending while an adder executing it as destination is busy.
    always_comb begin
        logic hazard;
        logic found;
        hazard = 1'b0;
        for (int u = 0; u < NUM_ADDERS; u++) begin
            if (unit_busy[u] && (unit_rd[u*AW +: AW] == dec_rs1 ||
                                 unit_rd[u*AW +: AW] == dec_rs2)) hazard = 1'b1;
        end
        issue_sel = '0;
        found     = 1'b0;
        for (int u = 0; u < NUM_ADDERS; u++) begin
            if (!found && !unit_busy[u]) begin
                issue_sel[u] = 1'b1;
                found        = 1'b1;
            end
        end
        if (hazard)      hold_cause = SRC_HAZARD;
        else if (!found) hold_cause = UNIT_FULL;
        else             hold_cause = SRC_OK;
        dispatch = id_valid && (hold_cause == SRC_OK);
        if (!dispatch) issue_sel = '0;
    end

    always_comb begin
        ctr_d         = ctr_q;
        ctr_d.cycles  = ctr_q.cycles + 1'b1;
        ctr_d.retired = ctr_q.retired + CW'($countones(wr_en));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign cycle_count  = ctr_q.cycles;
    assign retire_count = ctr_q.retired;

    // R4: at most one adder receives an instruction per cycle.
    assert_single_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(issue_sel));

    // R5: a held instruction stays in decode unchanged.
    assert_decode_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && !dispatch) |=> (id_valid && $stable(id_word)));

    // R7: the cycle counter advances by exactly one.
    assert_cycle_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cycle_count == $past(cycle_count) + 1'b1);

    // R7: the retire counter follows the write strobes of the previous cycle.
    assert_retire_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> retire_count == $past(retire_count) + CW'($countones($past(wr_en))));
endmodule

// File: tb/dual_adder_pipe_bench.sv
module dual_adder_pipe_bench;
    localparam int NREG  = 16;
    localparam int AW    = 4;
    localparam int DW    = 16;
    localparam int NA    = 2;
    localparam int LAT   = 2;
    localparam int CW    = 32;
    localparam int MAXC  = 256;
    localparam int MAXI  = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [3*AW-1:0] in_word = '0;
    logic            fetch_ready;
    logic [NA-1:0]   wr_en;
    logic [NA*AW-1:0] wr_addr;
    logic [NA*DW-1:0] wr_data;
    logic [CW-1:0]   cycle_count, retire_count;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dual_adder_pipe u_dual_adder_pipe (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .fetch_ready(fetch_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cycle_count(cycle_count), .retire_count(retire_count)
    );

    int p_rd [MAXI];
    int p_s1 [MAXI];
    int p_s2 [MAXI];
    int n_instr;

    int exp_en   [NA][MAXC];
    int exp_addr [NA][MAXC];
    int exp_data [NA][MAXC];
    int exp_acc  [MAXC];
    int exp_ret  [MAXC];
    int last_cycle;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic add_instr(input int rd, input int s1, input int s2);
        p_rd[n_instr] = rd; p_s1[n_instr] = s1; p_s2[n_instr] = s2;
        n_instr++;
    endtask

    // Schedule worked out from the stated rules, instruction by instruction.
    task automatic build_schedule();
        int regs [NREG];
        int ready [NREG];
        int unit_free [NA];
        int a_prev, s_prev, d_prev, a, s, c, u, w, v;
        bit ok;
        for (int i = 0; i < NREG; i++) begin regs[i] = i; ready[i] = 0; end
        for (int k = 0; k < NA; k++) unit_free[k] = 0;
        for (int cy = 0; cy < MAXC; cy++) begin
            exp_acc[cy] = -1; exp_ret[cy] = 0;
            for (int k = 0; k < NA; k++) begin
                exp_en[k][cy] = 0; exp_addr[k][cy] = 0; exp_data[k][cy] = 0;
            end
        end
        a_prev = -1; s_prev = 0; d_prev = -1; last_cycle = 0;
        for (int i = 0; i < n_instr; i++) begin
            a = (i == 0) ? 0 : ((a_prev + 1 > s_prev - 1) ? a_prev + 1 : s_prev - 1);
            s = (a + 2 > d_prev + 1) ? a + 2 : d_prev + 1;
            c = s;
            forever begin
                ok = (ready[p_s1[i]] <= c) && (ready[p_s2[i]] <= c);
                u = -1;
                for (int k = NA - 1; k >= 0; k--) if (unit_free[k] <= c) u = k;
                if (ok && u >= 0) break;
                c++;
            end
            w = c + LAT + 1;
            unit_free[u] = w;
            ready[p_rd[i]] = w;
            v = (regs[p_s1[i]] + regs[p_s2[i]]) % (1 << DW);
            regs[p_rd[i]] = v;
            exp_acc[a] = i;
            exp_en[u][w] = 1; exp_addr[u][w] = p_rd[i]; exp_data[u][w] = v;
            if (w > last_cycle) last_cycle = w;
            a_prev = a; s_prev = s; d_prev = c;
        end
        for (int cy = 1; cy < MAXC; cy++) begin
            exp_ret[cy] = exp_ret[cy-1];
            for (int k = 0; k < NA; k++) exp_ret[cy] += exp_en[k][cy-1];
        end
    endtask

    task automatic run_prog(input string tag);
        int idx;
        build_schedule();
        rst_n = 1'b0; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idx = 0;
        for (int c = 0; c <= last_cycle + 2; c++) begin
            in_valid = (idx < n_instr);
            in_word  = (idx < n_instr) ? {AW'(p_rd[idx]), AW'(p_s1[idx]), AW'(p_s2[idx])} : '0;
            #1;
            if (c == 0) begin
                check(fetch_ready && wr_en == '0 && retire_count == 0,
                      $sformatf("R1 reset state (%s)", tag), int'(wr_en), 0);
            end
            check(cycle_count == CW'(c), $sformatf("R7 cycle count c%0d (%s)", c, tag),
                  int'(cycle_count), c);
            check(retire_count == CW'(exp_ret[c]), $sformatf("R7 retire count c%0d (%s)", c, tag),
                  int'(retire_count), exp_ret[c]);
            for (int k = 0; k < NA; k++) begin
                check(int'(wr_en[k]) == exp_en[k][c],
                      $sformatf("R3 R4 port%0d strobe c%0d (%s)", k, c, tag),
                      int'(wr_en[k]), exp_en[k][c]);
                if (wr_en[k] && exp_en[k][c] == 1) begin
                    check(int'(wr_addr[k*AW +: AW]) == exp_addr[k][c],
                          $sformatf("R3 port%0d dest c%0d (%s)", k, c, tag),
                          int'(wr_addr[k*AW +: AW]), exp_addr[k][c]);
                    check(int'(wr_data[k*DW +: DW]) == exp_data[k][c],
                          $sformatf("R2 R8 port%0d value c%0d (%s)", k, c, tag),
                          int'(wr_data[k*DW +: DW]), exp_data[k][c]);
                end
            end
            if (in_valid) begin
                check((fetch_ready ? idx : -1) == exp_acc[c],
                      $sformatf("R5 fetch accept c%0d (%s)", c, tag),
                      fetch_ready ? idx : -1, exp_acc[c]);
                if (fetch_ready) idx++;
            end
            @(negedge clk);
        end
        check(idx == n_instr, $sformatf("R5 all words taken (%s)", tag), idx, n_instr);
    endtask

    initial begin
        // R6 bypass chain: each link reads its producer's result in the write-back cycle.
        n_instr = 0;
        add_instr(5, 6, 7); add_instr(3, 5, 4); add_instr(6, 3, 8); add_instr(9, 6, 3);
        run_prog("R6 dependent chain");

        // R4 mixed dependences with both adders in use.
        n_instr = 0;
        add_instr(3, 1, 2); add_instr(8, 9, 10); add_instr(4, 5, 6);
        add_instr(7, 1, 4); add_instr(12, 8, 2);
        run_prog("R4 mixed stream");

        // R4 four independent adds: the third waits for an adder.
        n_instr = 0;
        add_instr(1, 2, 3); add_instr(4, 5, 6); add_instr(7, 8, 9); add_instr(10, 11, 12);
        run_prog("R4 adder saturation");

        // R8 repeated doubling wraps past 2^DW; destination equals source.
        n_instr = 0;
        for (int i = 0; i < 17; i++) add_instr(1, 1, 1);
        add_instr(15, 15, 15);
        run_prog("R8 wrap doubling");

        // R5 same-destination writes without a read hazard, then a reader.
        n_instr = 0;
        add_instr(2, 2, 3); add_instr(2, 4, 5); add_instr(6, 2, 2); add_instr(0, 0, 15);
        run_prog("R5 write-after-write");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule